// File: doc/BRIEF.md
# Power-Up Programming-Pin Sequencer

This block sets the drive state of two dedicated programming-interface pads while the chip comes out of power-on reset. It runs on the fast system clock. It advances only on cycles where a slow sleep-clock enable pulses. It steps both pads through a fixed and asymmetric set of phases.

- **Lead phase.** The first pad is driven strongly high and the second is pulled resistively low.
- **Trail phase.** After a programmable number of sleep ticks (256 by default, about 8 ms on a 32 kHz sleep clock), the first pad drops to a resistive low.
- **Free phase.** After a second programmable count of ticks, both pads float. A release output rises at the same time to hand the chip over to normal CPU and GPIO operation.

Ordinary GPIO pads stay in high impedance until that release. Their configuration is handled elsewhere.

A power-on-reset level can arrive at any time, including after release. It is sampled on the system clock and throws the sequence back to the lead phase with the tick count cleared.

Top module: `pwrup_pin_seq`

## Requirements
- R1: While `por_i` is high, `pad_a_drv_o` = 2'b01 (strong high), `pad_b_drv_o` = 2'b10 (resistive low) and `release_o` = 0 on the clock cycle after it is sampled.
- R2: After reset, the lead drive (A = 01, B = 10) holds until `LEAD_TICKS` enabled sleep ticks have been counted.
- R3: On the clock edge that counts the `LEAD_TICKS`-th tick, A becomes 2'b10 (resistive low) while B stays 2'b10.
- R4: On the edge that counts a further `TRAIL_TICKS` ticks, both pads become 2'b00 (high impedance) and `release_o` rises in that same cycle.
- R5: Once released, `release_o` stays 1 and both pads stay 2'b00 until `por_i` is asserted again, whatever the tick input does.
- R6: Clock cycles with `slow_tick_i` low do not advance the sequence.
- R7: Asserting `por_i` in any phase returns the block to the lead phase with its count cleared, so a full `LEAD_TICKS` ticks are again needed before the trail phase.
- R8: The drive encoding is 00 high-Z, 01 strong high, 10 resistive low; code 11 never appears on either pad output.
- R9: When `por_i` and `slow_tick_i` are high in the same cycle, reset wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| slow_tick_i | input | 1 | One-cycle enable per sleep-oscillator period |
| pad_a_drv_o | output | 2 | Drive state of programming pad A |
| pad_b_drv_o | output | 2 | Drive state of programming pad B |
| release_o | output | 1 | High once normal operation may begin |

## Verification
Two events can land in one cycle: a reset and the sleep tick that would end the current phase. The bench provokes this in two ways.

- **Directed collisions.** It drives `por_i` high together with the terminal tick of the lead phase and of the trail phase.
- **Random collisions.** Sparse reset pulses are scattered over random tick traffic, so some of them coincide with phase-ending ticks.

The reference model counts only ticks seen without reset. The outcome is judged by expecting the lead drive and a low release on the next sample. It is also judged by requiring a full lead count again afterwards.

// File: rtl/pwrup_pin_seq_pkg.sv
package pwrup_pin_seq_pkg;

    typedef enum logic [1:0] {
        DRV_HIZ    = 2'b00,
        DRV_STRONG = 2'b01,
        DRV_WEAK0  = 2'b10
    } pad_drv_e;

    typedef enum logic [1:0] {
        PH_LEAD  = 2'd0,
        PH_TRAIL = 2'd1,
        PH_FREE  = 2'd2
    } seq_phase_e;

    typedef struct packed {
        pad_drv_e pad_a;
        pad_drv_e pad_b;
        logic     rel;
    } pad_bundle_t;

    function automatic int unsigned max_u(input int unsigned x, input int unsigned y);
        return (x > y) ? x : y;
    endfunction

    function automatic pad_bundle_t phase_to_pads(input seq_phase_e ph);
        pad_bundle_t b;
        unique case (ph)
            PH_LEAD:  b = '{pad_a: DRV_STRONG, pad_b: DRV_WEAK0, rel: 1'b0};
            PH_TRAIL: b = '{pad_a: DRV_WEAK0,  pad_b: DRV_WEAK0, rel: 1'b0};
            PH_FREE:  b = '{pad_a: DRV_HIZ,    pad_b: DRV_HIZ,   rel: 1'b1};
            default:  b = '{pad_a: DRV_STRONG, pad_b: DRV_WEAK0, rel: 1'b0};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pwrup_tick_counter.sv
module pwrup_tick_counter #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] limit_m1_i,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap_o = tick_i && !hold_i && (cnt_q == limit_m1_i);

    always_ff @(posedge clk) begin
        if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i && !hold_i) begin
            if (cnt_q == limit_m1_i) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (clear_i)
        (!tick_i && !clear_i) |=> $stable(cnt_q));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (clear_i)
        $fell(clear_i) |-> (cnt_q == '0));

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (clear_i)
        hold_i || (cnt_q <= limit_m1_i));

endmodule

// File: rtl/pwrup_phase_fsm.sv
module pwrup_phase_fsm
    import pwrup_pin_seq_pkg::*;
(
    input  logic       clk,
    input  logic       por_i,
    input  logic       wrap_i,
    output seq_phase_e phase_o
);
    seq_phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LEAD:  if (wrap_i) phase_d = PH_TRAIL;
            PH_TRAIL: if (wrap_i) phase_d = PH_FREE;
            PH_FREE:  phase_d = PH_FREE;
            default:  phase_d = PH_LEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            phase_q <= PH_LEAD;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase_o = phase_q;

    // R5
    free_sticky_chk: assert property (@(posedge clk) disable iff (por_i)
        (phase_q == PH_FREE) |=> (phase_q == PH_FREE));

    // R2
    lead_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (phase_q == PH_LEAD && !wrap_i) |=> (phase_q == PH_LEAD));

    // R7
    restart_lead_chk: assert property (@(posedge clk) disable iff (por_i)
        $fell(por_i) |-> (phase_q == PH_LEAD));

endmodule

// File: rtl/pwrup_pad_map.sv
module pwrup_pad_map
    import pwrup_pin_seq_pkg::*;
(
    input  logic       clk,
    input  logic       por_i,
    input  seq_phase_e phase_i,
    output logic [1:0] pad_a_o,
    output logic [1:0] pad_b_o,
    output logic       rel_o
);
    pad_bundle_t bundle;

    always_comb begin
        bundle  = phase_to_pads(phase_i);
        pad_a_o = bundle.pad_a;
        pad_b_o = bundle.pad_b;
        rel_o   = bundle.rel;
    end

    // R8
    enc_legal_chk: assert property (@(posedge clk) disable iff (por_i)
        (pad_a_o != 2'b11) && (pad_b_o != 2'b11));

endmodule

// File: rtl/pwrup_pin_seq.sv
module pwrup_pin_seq
    import pwrup_pin_seq_pkg::*;
#(
    parameter int unsigned LEAD_TICKS  = 256,
    parameter int unsigned TRAIL_TICKS = 256
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       slow_tick_i,
    output logic [1:0] pad_a_drv_o,
    output logic [1:0] pad_b_drv_o,
    output logic       release_o
);
    localparam int unsigned MAX_TICKS = max_u(LEAD_TICKS, TRAIL_TICKS);
    localparam int unsigned CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
    localparam logic [CNT_W-1:0] LEAD_M1  = CNT_W'(LEAD_TICKS - 1);
    localparam logic [CNT_W-1:0] TRAIL_M1 = CNT_W'(TRAIL_TICKS - 1);

    seq_phase_e       phase;
    logic             wrap;
    logic             in_free;
    logic [CNT_W-1:0] limit_m1;

    assign in_free  = (phase == PH_FREE);
    assign limit_m1 = (phase == PH_LEAD) ? LEAD_M1 : TRAIL_M1;

    pwrup_tick_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .clear_i    (por_i),
        .tick_i     (slow_tick_i),
        .hold_i     (in_free),
        .limit_m1_i (limit_m1),
        .wrap_o     (wrap)
    );

    pwrup_phase_fsm i_fsm (
        .clk     (clk),
        .por_i   (por_i),
        .wrap_i  (wrap),
        .phase_o (phase)
    );

    pwrup_pad_map i_map (
        .clk     (clk),
        .por_i   (por_i),
        .phase_i (phase),
        .pad_a_o (pad_a_drv_o),
        .pad_b_o (pad_b_drv_o),
        .rel_o   (release_o)
    );

    // R4
    release_floats_chk: assert property (@(posedge clk) disable iff (por_i)
        release_o |-> (pad_a_drv_o == 2'b00 && pad_b_drv_o == 2'b00));

    // R5
    release_sticky_chk: assert property (@(posedge clk) disable iff (por_i)
        release_o |=> release_o);

    // R9
    por_beats_tick_chk: assert property (@(posedge clk) disable iff (por_i)
        $fell(por_i) |-> (pad_a_drv_o == 2'b01 && !release_o));

endmodule

// File: tb/test_pwrup_pin_seq.sv
module test_pwrup_pin_seq;
    localparam int LEAD  = 256;
    localparam int TRAIL = 256;

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       slow_tick_i = 1'b0;
    logic [1:0] pad_a_drv_o, pad_b_drv_o;
    logic       release_o;

    int tests = 0;
    int fails = 0;
    int ticks = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pwrup_pin_seq #(.LEAD_TICKS(LEAD), .TRAIL_TICKS(TRAIL)) i_pwrup_pin_seq (
        .clk         (clk),
        .por_i       (por_i),
        .slow_tick_i (slow_tick_i),
        .pad_a_drv_o (pad_a_drv_o),
        .pad_b_drv_o (pad_b_drv_o),
        .release_o   (release_o)
    );

    // expected {a, b, rel} from ticks counted since reset
    function automatic logic [4:0] expect_pads(input int t);
        if (t < LEAD)              return {2'b01, 2'b10, 1'b0};
        else if (t < LEAD + TRAIL) return {2'b10, 2'b10, 1'b0};
        else                       return {2'b00, 2'b00, 1'b1};
    endfunction

    function automatic string req_of(input int t, input bit in_por);
        if (in_por)                return "R1";
        else if (t < LEAD)         return "R2";
        else if (t == LEAD)        return "R3";
        else if (t < LEAD + TRAIL) return "R3";
        else if (t == LEAD + TRAIL) return "R4";
        else                       return "R5";
    endfunction

    task automatic check(input string req);
        logic [4:0] got, exp;
        got = {pad_a_drv_o, pad_b_drv_o, release_o};
        exp = expect_pads(ticks);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got a=%b b=%b rel=%b expected a=%b b=%b rel=%b",
                     req, got[4:3], got[2:1], got[0], exp[4:3], exp[2:1], exp[0]);
        end
        tests++;
        if (pad_a_drv_o === 2'b11 || pad_b_drv_o === 2'b11) begin
            fails++;
            $display("FAIL R8: illegal code a=%b b=%b expected no 11", pad_a_drv_o, pad_b_drv_o);
        end
    endtask

    // one cycle: drive at negedge, model after posedge, sample 1 ns later
    task automatic step(input bit p, input bit t, input string req);
        @(negedge clk);
        por_i = p;
        slow_tick_i = t;
        @(posedge clk);
        #1;
        if (p) ticks = 0;
        else if (t && ticks < LEAD + TRAIL) ticks++;
        else if (t) ticks = LEAD + TRAIL + 1;
        check((req == "") ? req_of(ticks, p) : req);
    endtask

    task automatic ticks_to(input int target, input string req);
        while (ticks < target) step(1'b0, 1'b1, req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R1");
        // R6 idle cycles hold the lead phase
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, "R6");
        // R2 reach one tick before the lead boundary
        ticks_to(LEAD - 1, "R2");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, "R6");
        // R9 reset collides with the terminal lead tick
        step(1'b1, 1'b1, "R9");
        // R7 full lead count needed again
        ticks_to(LEAD - 1, "R7");
        step(1'b0, 1'b1, "R3");
        // R9 collision on the terminal trail tick
        ticks_to(LEAD + TRAIL - 1, "R3");
        step(1'b1, 1'b1, "R9");
        // R4 full run to release
        ticks_to(LEAD + TRAIL, "R4");
        // R5 release sticks under more ticks
        for (int i = 0; i < 30; i++) step(1'b0, i[0], "R5");
        // R7 reset after release
        step(1'b1, 1'b0, "R7");
        // random traffic with sparse resets
        for (int i = 0; i < 30000; i++) begin
            step(($urandom % 1500) == 0, ($urandom % 4) == 0, "");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule